// File: doc/BRIEF.md
# Strap-Derived Register Resync Sequencer

After the configuration strap inputs have taken new values, several registers that take their defaults from those straps must be rewritten so that they agree with the straps again. This block issues those writes. A one-cycle start pulse launches a fixed sequence of thirteen whole-word register writes. The sequence covers, in order: physical PHY port 1, physical PHY port 2, and the virtual PHY, each with three registers. It then writes the LED configuration register and three manual flow-control registers. A combinational generator computes every write value from a copy of the straps taken at start. Each basic-control write also has the restart-auto-negotiation bit set, so that negotiation runs again with the advertisement value that was just written.

The writes leave on a valid/ready port. When `wr_valid_o` is high, the address and data are held constant until a cycle in which `wr_ready_i` is also high. That cycle completes the write, and the next entry is presented in the following cycle. While `wr_ready_i` is held high, one write completes per cycle. A one-cycle `done_o` pulse follows the final write.

Top module: `strap_resync_seq`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after reset is released, `wr_valid_o` and `done_o` are low until a start is accepted. `wr_ready_i` is ignored while no sequence runs.
- R2: A start accepted while idle makes `wr_valid_o` high in the next cycle. The block then presents thirteen writes in this address order: 0x24,0x28,0x20 (port 1); 0x34,0x38,0x30 (port 2); 0x44,0x48,0x40 (virtual PHY); 0x60 (LED); 0x64,0x68,0x6C (flow control for port 1, port 2 and the host MAC port).
- R3: Each write is a 32-bit word with the upper 16 bits zero. For group g (0 = port 1, 1 = port 2, 2 = virtual PHY), let n = straps[4g+3:4g]. The advertisement word at 0x24/0x34/0x44 is 0x0001 | (n << 5).
- R4: The special-modes / special control word at 0x28/0x38/0x48 is 0x00E0 | n.
- R5: The basic-control word at 0x20/0x30/0x40 is 0x1000 when n is nonzero and 0x2100 when n is zero. In both cases the restart-auto-negotiation bit (bit 9, 0x0200) is ORed in.
- R6: The LED word is 0x0030 | (straps[15:12] << 8). The flow-control word for entry k (k = 0, 1, 2 at 0x64, 0x68, 0x6C) is 0x0006 when straps[12+k] is 1 and 0 otherwise.
- R7: While `wr_valid_o` is high and `wr_ready_i` is low, the valid signal, the address and the data hold unchanged. With `wr_ready_i` held high, one write completes per cycle.
- R8: A start pulse that arrives while a sequence is running has no effect. The sequence continues unchanged, and no second sequence follows it.
- R9: `done_o` is high for exactly one cycle, the cycle after the final write completes. `wr_valid_o` is low in that cycle.
- R10: All write values use the straps sampled in the cycle the start is accepted. Changes to `straps_i` during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| straps_i | input | 16 | Configuration strap vector |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 32 | Whole-word write value |
| wr_ready_i | input | 1 | Target accepts the write this cycle |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
A wrong step index would show up on the very first write after the fault, as an address out of the required order. A stall that fails to hold the index would show up one cycle after the stall began, as an address or data value that changes while ready is low. A corrupted strap snapshot, or a wrong default term, would show up on the first write whose value depends on the bad bits. A fault in the end-of-sequence logic would show up in the cycle after the thirteenth write, as a missing or stretched done pulse or as valid reasserting.

// File: rtl/strap_resync_pkg.sv
package strap_resync_pkg;
  localparam int STRAP_W      = 16;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 32;
  localparam int PHY_GROUPS   = 3;
  localparam int REGS_PER_PHY = 3;
  localparam int FC_PORTS     = 3;
  localparam int NUM_STEPS    = PHY_GROUPS * REGS_PER_PHY + 1 + FC_PORTS;
  localparam int IDX_W        = $clog2(NUM_STEPS);
  localparam int RESTART_BIT  = 9;
  localparam int FC_STRAP_LSB = 12;

  localparam logic [ADDR_W-1:0] PHY_BASE   = 8'h20;
  localparam logic [ADDR_W-1:0] PHY_STRIDE = 8'h10;
  localparam logic [ADDR_W-1:0] LED_ADDR   = 8'h60;
  localparam logic [ADDR_W-1:0] FC_BASE    = 8'h64;

  typedef enum logic [2:0] {
    K_ADV   = 3'd0,
    K_SPEC  = 3'd1,
    K_BASIC = 3'd2,
    K_LED   = 3'd3,
    K_FC    = 3'd4
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [1:0]  unit;
  } step_t;
endpackage

// File: rtl/resync_step_map.sv
module resync_step_map
  import strap_resync_pkg::*;
#(
  parameter int N_STEPS = NUM_STEPS,
  parameter int IW      = IDX_W
) (
  input  logic [IW-1:0]     idx_i,
  output step_t             step_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PHY_STEPS = PHY_GROUPS * REGS_PER_PHY;

  always_comb begin
    int i;
    int g;
    int r;
    i = int'(idx_i);
    step_o = '{kind: K_LED, unit: 2'd0};
    addr_o = LED_ADDR;
    if (i < PHY_STEPS) begin
      g = i / REGS_PER_PHY;
      r = i % REGS_PER_PHY;
      step_o.unit = 2'(g);
      addr_o = PHY_BASE + ADDR_W'(g) * PHY_STRIDE;
      case (r)
        0: begin step_o.kind = K_ADV;   addr_o = addr_o + 8'h04; end
        1: begin step_o.kind = K_SPEC;  addr_o = addr_o + 8'h08; end
        default: step_o.kind = K_BASIC;
      endcase
    end else if (i > PHY_STEPS && i < N_STEPS) begin
      step_o.kind = K_FC;
      step_o.unit = 2'(i - PHY_STEPS - 1);
      addr_o = FC_BASE + ADDR_W'(4 * (i - PHY_STEPS - 1));
    end
  end
endmodule

// File: rtl/resync_defaults.sv
module resync_defaults
  import strap_resync_pkg::*;
(
  input  step_t              step_i,
  input  logic [STRAP_W-1:0] straps_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam logic [15:0] RESTART_MASK = 16'(1) << RESTART_BIT;

  logic [15:0] adv_w   [PHY_GROUPS];
  logic [15:0] spec_w  [PHY_GROUPS];
  logic [15:0] basic_w [PHY_GROUPS];
  logic [15:0] fc_w    [FC_PORTS];
  logic [15:0] led_w;

  for (genvar g = 0; g < PHY_GROUPS; g++) begin : g_phy
    logic [3:0] nib;
    assign nib        = straps_i[4*g +: 4];
    assign adv_w[g]   = 16'h0001 | {7'b0, nib, 5'b0};
    assign spec_w[g]  = 16'h00E0 | {12'b0, nib};
    assign basic_w[g] = ((nib != 4'b0) ? 16'h1000 : 16'h2100) | RESTART_MASK;
  end

  for (genvar k = 0; k < FC_PORTS; k++) begin : g_fc
    assign fc_w[k] = straps_i[FC_STRAP_LSB + k] ? 16'h0006 : 16'h0000;
  end

  assign led_w = 16'h0030 | {4'b0, straps_i[15:12], 8'b0};

  always_comb begin
    logic [15:0] w;
    w = 16'h0000;
    case (step_i.kind)
      K_ADV:   if (int'(step_i.unit) < PHY_GROUPS) w = adv_w[step_i.unit];
      K_SPEC:  if (int'(step_i.unit) < PHY_GROUPS) w = spec_w[step_i.unit];
      K_BASIC: if (int'(step_i.unit) < PHY_GROUPS) w = basic_w[step_i.unit];
      K_LED:   w = led_w;
      K_FC:    if (int'(step_i.unit) < FC_PORTS) w = fc_w[step_i.unit];
      default: w = 16'h0000;
    endcase
    data_o = {{(DATA_W-16){1'b0}}, w};
  end
endmodule

// File: rtl/resync_ctrl.sv
module resync_ctrl
  import strap_resync_pkg::*;
#(
  parameter int N_STEPS = NUM_STEPS,
  parameter int IW      = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [STRAP_W-1:0] straps_i,
  input  logic               ready_i,
  output logic               busy_o,
  output logic [IW-1:0]      idx_o,
  output logic [STRAP_W-1:0] snap_o,
  output logic               done_o
);
  localparam logic [IW-1:0] LAST = IW'(N_STEPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      snap_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          idx_o  <= '0;
          snap_o <= straps_i;
        end
      end else if (ready_i) begin
        if (idx_o == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !ready_i |=> busy_o && $stable(idx_o));
  assert_snap_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(snap_o));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !ready_i |=> $stable(idx_o) && $stable(snap_o));
endmodule

// File: rtl/strap_resync_seq.sv
module strap_resync_seq
  import strap_resync_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [STRAP_W-1:0] straps_i,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  input  logic               wr_ready_i,
  output logic               done_o
);
  logic               busy;
  logic [IDX_W-1:0]   idx;
  logic [STRAP_W-1:0] snap;
  step_t              step;

  resync_ctrl #(.N_STEPS(NUM_STEPS), .IW(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .straps_i (straps_i),
    .ready_i  (wr_ready_i),
    .busy_o   (busy),
    .idx_o    (idx),
    .snap_o   (snap),
    .done_o   (done_o)
  );

  resync_step_map #(.N_STEPS(NUM_STEPS), .IW(IDX_W)) u_map (
    .idx_i  (idx),
    .step_o (step),
    .addr_o (wr_addr_o)
  );

  resync_defaults u_defs (
    .step_i   (step),
    .straps_i (snap),
    .data_o   (wr_data_o)
  );

  assign wr_valid_o = busy;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  assert_restart_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && step.kind == K_BASIC |-> wr_data_o[RESTART_BIT]);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_data_o[DATA_W-1:16] == '0);
  assert_no_valid_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_valid_o);
endmodule

// File: tb/strap_resync_seq_test.sv
`timescale 1ns/1ps
module strap_resync_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] straps = 16'h0;
  logic        ready = 1'b0;
  logic        valid;
  logic [7:0]  addr;
  logic [31:0] data;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  strap_resync_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .straps_i(straps),
    .wr_valid_o(valid), .wr_addr_o(addr), .wr_data_o(data),
    .wr_ready_i(ready), .done_o(done)
  );

  // {straps[15:0], stall mask[12:0], poke start mid-run, change straps mid-run, pad}
  localparam int NV = 4;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0000, 13'h0000, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 13'h1555, 1'b1, 1'b0, 1'b0},
    {16'hA5C3, 13'h0A0F, 1'b0, 1'b1, 1'b0},
    {16'h7E18, 13'h1FFF, 1'b1, 1'b1, 1'b0}
  };

  function automatic logic [7:0] exp_addr(input int i);
    logic [7:0] off [3] = '{8'h04, 8'h08, 8'h00};
    if (i < 9) return 8'h20 + 8'(16 * (i / 3)) + off[i % 3];
    return 8'h60 + 8'(4 * (i - 9));
  endfunction

  function automatic logic [31:0] exp_data(input int i, input logic [15:0] s);
    logic [3:0] n;
    if (i < 9) begin
      n = s[4*(i/3) +: 4];
      case (i % 3)
        0: return {16'h0, 16'h0001 | {7'b0, n, 5'b0}};
        1: return {16'h0, 16'h00E0 | {12'b0, n}};
        default: return {16'h0, ((n != 0) ? 16'h1000 : 16'h2100) | 16'h0200};
      endcase
    end
    if (i == 9) return {16'h0, 16'h0030 | {4'b0, s[15:12], 8'b0}};
    return s[12 + (i - 10)] ? 32'h6 : 32'h0;
  endfunction

  function automatic string tag_of(input int i);
    if (i >= 9) return "R6";
    case (i % 3)
      0: return "R3";
      1: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_write(input int i, input logic [15:0] s, input string extra);
    check(valid === 1'b1, "R2", {"valid ", extra}, 32'(valid), 32'h1);
    check(addr === exp_addr(i), "R2", {"address order ", extra}, 32'(addr), 32'(exp_addr(i)));
    check(data === exp_data(i, s), tag_of(i), {"data ", extra}, data, exp_data(i, s));
  endtask

  task automatic run_vec(input logic [15:0] s, input logic [12:0] stall,
                         input bit poke, input bit chg);
    @(negedge clk); straps = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (chg) straps = ~s;  // R10: run must keep using s
    for (int i = 0; i < 13; i++) begin
      if (stall[i]) begin
        ready = 1'b0;
        check_write(i, s, "pre-stall R10");
        @(negedge clk);
        check_write(i, s, "held under back-pressure R7");
      end
      ready = 1'b1;
      if (poke && i == 5) start = 1'b1;  // R8: must be ignored
      check_write(i, s, "accept");
      @(negedge clk);
      start = 1'b0;
    end
    ready = 1'b0;
    check(done === 1'b1 && valid === 1'b0, "R9", "done pulse after final write",
          {30'h0, done, valid}, 32'h2);
    @(negedge clk);
    check(done === 1'b0, "R9", "done lasts one cycle", 32'(done), 32'h0);
    check(valid === 1'b0, "R8", "no second sequence", 32'(valid), 32'h0);
    straps = s;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && done === 1'b0, "R1", "outputs during reset",
          {30'h0, valid, done}, 32'h0);
    rst_n = 1'b1;
    ready = 1'b1;  // R1: ready while idle must not matter
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && done === 1'b0, "R1", "idle after reset with ready high",
          {30'h0, valid, done}, 32'h0);
    ready = 1'b0;

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][31:16], VEC[v][15:3], VEC[v][2], VEC[v][1]);

    // R7: back-to-back throughput with ready high, checked cycle by cycle
    @(negedge clk); straps = 16'h1234; start = 1'b1; ready = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 13; i++) begin
      check_write(i, 16'h1234, "one per cycle R7");
      @(negedge clk);
    end
    check(done === 1'b1, "R9", "done after streaming run", 32'(done), 32'h1);
    ready = 1'b0;
    @(negedge clk);

    // R2: first write appears in the cycle after start
    @(negedge clk); straps = 16'h0F0F; start = 1'b1;
    check(valid === 1'b0, "R2", "no valid in start cycle", 32'(valid), 32'h0);
    @(negedge clk); start = 1'b0;
    check_write(0, 16'h0F0F, "first after start");
    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(valid === 1'b0 && done === 1'b0, "R1", "reset aborts run",
          {30'h0, valid, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid === 1'b0, "R1", "idle after mid-run reset", 32'(valid), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule